// File: doc/BRIEF.md
# Carry-Save Result Queue Converter

This block sits on the result path of a pipelined multiplier whose partial result arrives in carry-save form: a sum vector and a carry vector whose true value is `sum + (carry << 1)`, taken modulo 2^W. A downstream consumer takes one result per cycle whenever it is not busy. If the consumer is free and nothing is waiting, the redundant pair is forwarded unchanged in the same cycle, so it never passes through a carry-propagate adder.

If the consumer is busy, or older results are still waiting, the incoming pair is first resolved by a carry-propagate adder into an ordinary binary word. That word is stored in a FIFO that is W bits wide instead of 2W. A three-way output selector chooses between zero, the bypassed pair and the dequeued binary word. A dequeued word is presented as the sum vector with the carry vector forced to zero, so the consumer always sees the same redundant interface. The resolved binary value of whatever is presented is also driven on a separate output.

Top module: `csq_result_path`

## Requirements
- R1: After reset the FIFO is empty and not full, `out_valid` is 0, the overflow flag is 0, and `out_sum`, `out_carry` and `out_bin` are all zero.
- R2: When `cons_busy` is 0, the FIFO is empty and `in_valid` is 1, the same cycle shows `out_valid`=1, `out_sum`=`in_sum` and `out_carry`=`in_carry`, and nothing is enqueued.
- R3: Whenever `out_valid` is 1, `out_bin` equals (`out_sum` + 2·`out_carry`) mod 2^W.
- R4: When `in_valid` is 1 and the pair is not bypassed and not dropped, the FIFO stores (`in_sum` + 2·`in_carry`) mod 2^W as one W-bit entry.
- R5: When `cons_busy` is 0 and the FIFO is not empty, the head entry is presented that cycle on `out_sum` with `out_carry`=0 and `out_valid`=1, and it is removed at the next clock edge.
- R6: Results leave in arrival order. While the FIFO holds entries, a new input is queued behind them and is never bypassed.
- R7: When no result is presented (`cons_busy`=1, or nothing is available), `out_valid` is 0 and `out_sum`, `out_carry` and `out_bin` are all zero.
- R8: `fifo_full` is 1 exactly when DEPTH entries are stored. `fifo_empty` is 1 exactly when none are stored.
- R9: `in_valid`=1 while `cons_busy`=1 and the FIFO is full drops the input and sets `ovf_err` at the next edge. `ovf_err` then stays 1 until reset.
- R10: When the FIFO is full and `cons_busy` is 0, a new input is accepted in the same cycle as the head is dequeued, with no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming redundant result is valid |
| in_sum | input | W | Incoming sum vector |
| in_carry | input | W | Incoming carry vector (weight shifted by one) |
| cons_busy | input | 1 | Consumer cannot take a result this cycle |
| out_valid | output | 1 | A result is presented this cycle |
| out_sum | output | W | Presented sum vector |
| out_carry | output | W | Presented carry vector (zero for dequeued words) |
| out_bin | output | W | Nonredundant value of the presented result |
| fifo_full | output | 1 | FIFO holds DEPTH entries |
| fifo_empty | output | 1 | FIFO holds no entries |
| ovf_err | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with W=8, DEPTH=3 and the bit-level ripple adder variant. With a depth that is not a power of two, the pointer wrap is exercised after only a few pushes, and full, overflow and simultaneous push-and-pop are quickly reached. An 8-bit width makes the modulo wrap of `sum + 2·carry` frequent under random operands. A behavioural queue model predicts every output on every cycle. The directed phases are bypass, fill, overflow, drain while full and zero seeding, and a long random phase follows them.

// File: rtl/csq_pkg.sv
package csq_pkg;
   typedef enum logic [1:0] {
      SEL_ZERO   = 2'd0,
      SEL_BYPASS = 2'd1,
      SEL_QUEUE  = 2'd2
   } csq_sel_e;
endpackage

// File: rtl/csq_cpa.sv
// Carry-propagate resolution of a carry-save pair: sum + (carry << 1) mod 2^W.
module csq_cpa #(
   parameter int W     = 16,
   parameter int STYLE = 0   // 0: operator adder, 1: explicit ripple chain
) (
   input  logic [W-1:0] sum_i,
   input  logic [W-1:0] carry_i,
   output logic [W-1:0] value_o
);
   logic [W-1:0] addend;
   assign addend = {carry_i[W-2:0], 1'b0};

   if (STYLE == 0) begin : g_op
      assign value_o = sum_i + addend;
   end else begin : g_ripple
      logic [W:0] cy;
      assign cy[0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign value_o[i] = sum_i[i] ^ addend[i] ^ cy[i];
         assign cy[i+1]    = (sum_i[i] & addend[i]) | (cy[i] & (sum_i[i] ^ addend[i]));
      end
      logic unused_cy;
      assign unused_cy = cy[W];
   end
endmodule

// File: rtl/csq_fifo.sv
// Single-clock FIFO of nonredundant words, any depth >= 2.
module csq_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] head,
   output logic         full,
   output logic         empty
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
   localparam logic [CW-1:0] FULLC = CW'(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
         if (push && !pop)      count <= count + 1'b1;
         else if (pop && !push) count <= count - 1'b1;
      end
   end

   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      always_ff @(posedge clk) begin
         if (push && wr_ptr == PW'(e)) mem[e] <= wdata;
      end
   end

   assign head  = mem[rd_ptr];
   assign full  = (count == FULLC);
   assign empty = (count == '0);
endmodule

// File: rtl/csq_result_path.sv
module csq_result_path
   import csq_pkg::*;
#(
   parameter int W         = 16,
   parameter int DEPTH     = 4,
   parameter int CPA_STYLE = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_sum,
   input  logic [W-1:0] in_carry,
   input  logic         cons_busy,
   output logic         out_valid,
   output logic [W-1:0] out_sum,
   output logic [W-1:0] out_carry,
   output logic [W-1:0] out_bin,
   output logic         fifo_full,
   output logic         fifo_empty,
   output logic         ovf_err
);
   if (W < 2) begin : g_bad_w
      $error("csq_result_path: W must be at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("csq_result_path: DEPTH must be at least 2");
   end
   if (CPA_STYLE != 0 && CPA_STYLE != 1) begin : g_bad_style
      $error("csq_result_path: CPA_STYLE must be 0 or 1");
   end

   logic [W-1:0] resolved;
   logic [W-1:0] head;
   logic         push, pop, drop;
   csq_sel_e     sel;

   csq_cpa #(.W(W), .STYLE(CPA_STYLE)) u_cpa (
      .sum_i   (in_sum),
      .carry_i (in_carry),
      .value_o (resolved)
   );

   csq_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .pop   (pop),
      .wdata (resolved),
      .head  (head),
      .full  (fifo_full),
      .empty (fifo_empty)
   );

   // Queue drains first; bypass only when nothing is waiting.
   always_comb begin
      pop  = !cons_busy && !fifo_empty;
      sel  = SEL_ZERO;
      if (pop)                            sel = SEL_QUEUE;
      else if (!cons_busy && in_valid)    sel = SEL_BYPASS;
      push = in_valid && (sel != SEL_BYPASS) && (!fifo_full || pop);
      drop = in_valid && cons_busy && fifo_full;
   end

   always_comb begin
      out_valid = 1'b0;
      out_sum   = '0;
      out_carry = '0;
      out_bin   = '0;
      case (sel)
         SEL_BYPASS: begin
            out_valid = 1'b1;
            out_sum   = in_sum;
            out_carry = in_carry;
            out_bin   = resolved;
         end
         SEL_QUEUE: begin
            out_valid = 1'b1;
            out_sum   = head;
            out_bin   = head;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ovf_err <= 1'b0;
      else if (drop) ovf_err <= 1'b1;
   end
endmodule

// File: rtl/csq_result_path_chk.sv
module csq_result_path_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         in_valid,
   input logic [W-1:0] in_sum,
   input logic [W-1:0] in_carry,
   input logic         cons_busy,
   input logic         out_valid,
   input logic [W-1:0] out_sum,
   input logic [W-1:0] out_carry,
   input logic [W-1:0] out_bin,
   input logic         fifo_full,
   input logic         fifo_empty,
   input logic         ovf_err
);
   // R2
   bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_empty && !cons_busy && in_valid) |->
         (out_valid && out_sum == in_sum && out_carry == in_carry));

   // R3
   bin_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_bin == W'(out_sum + {out_carry[W-2:0], 1'b0})));

   // R6
   queue_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_empty && !cons_busy) |-> (out_valid && out_carry == '0));

   // R7
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_sum == '0 && out_carry == '0 && out_bin == '0));

   // R7
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cons_busy |-> !out_valid);

   // R8
   flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_full && fifo_empty));

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cons_busy && fifo_full) |=> ovf_err);

   // R9
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err |=> ovf_err);
endmodule

bind csq_result_path csq_result_path_chk #(.W(W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_sum     (in_sum),
   .in_carry   (in_carry),
   .cons_busy  (cons_busy),
   .out_valid  (out_valid),
   .out_sum    (out_sum),
   .out_carry  (out_carry),
   .out_bin    (out_bin),
   .fifo_full  (fifo_full),
   .fifo_empty (fifo_empty),
   .ovf_err    (ovf_err)
);

// File: tb/csq_result_path_test.sv
module csq_result_path_test;
   localparam int W     = 8;
   localparam int DEPTH = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_sum = '0;
   logic [W-1:0] in_carry = '0;
   logic         cons_busy = 1'b0;
   logic         out_valid;
   logic [W-1:0] out_sum, out_carry, out_bin;
   logic         fifo_full, fifo_empty, ovf_err;

   always #5 clk = ~clk;

   csq_result_path #(.W(W), .DEPTH(DEPTH), .CPA_STYLE(1)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sum(in_sum),
      .in_carry(in_carry), .cons_busy(cons_busy), .out_valid(out_valid),
      .out_sum(out_sum), .out_carry(out_carry), .out_bin(out_bin),
      .fifo_full(fifo_full), .fifo_empty(fifo_empty), .ovf_err(ovf_err)
   );

   int n_checks = 0;
   int n_fail   = 0;
   logic [W-1:0] q[$];
   logic m_ovf = 1'b0;
   bit   done = 1'b0;

   task automatic chk(input string req, input string what, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   function automatic logic [W-1:0] resolve(input logic [W-1:0] s, input logic [W-1:0] c);
      int v;
      v = (int'(s) + 2 * int'(c)) % (1 << W);
      return W'(v);
   endfunction

   // Drive one cycle, check against the model before the next edge, then advance the model.
   task automatic step(input logic v, input logic [W-1:0] s, input logic [W-1:0] c, input logic b);
      logic e_valid;
      logic [W-1:0] e_sum, e_carry, e_bin;
      logic popping, was_full;
      string tag;
      @(posedge clk); #1;
      in_valid = v; in_sum = s; in_carry = c; cons_busy = b;
      #3;
      was_full = (q.size() == DEPTH);
      popping  = !b && q.size() != 0;
      e_valid = 1'b0; e_sum = '0; e_carry = '0; e_bin = '0;
      tag = "R7";
      if (popping) begin
         e_valid = 1'b1; e_sum = q[0]; e_bin = q[0];
         tag = (v) ? "R6" : "R5";
      end else if (!b && v) begin
         e_valid = 1'b1; e_sum = s; e_carry = c; e_bin = resolve(s, c);
         tag = "R2";
      end
      chk(tag, "out_valid", int'(out_valid), int'(e_valid));
      chk(popping ? "R4" : tag, "out_sum", int'(out_sum), int'(e_sum));
      chk(tag, "out_carry", int'(out_carry), int'(e_carry));
      chk("R3", "out_bin", int'(out_bin), int'(e_bin));
      chk("R8", "fifo_full", int'(fifo_full), int'(was_full));
      chk("R8", "fifo_empty", int'(fifo_empty), int'(q.size() == 0));
      chk("R9", "ovf_err", int'(ovf_err), int'(m_ovf));
      // model update for the coming edge
      if (popping) void'(q.pop_front());
      if (v && !(!b && !popping)) begin
         if (!was_full || popping) begin
            q.push_back(resolve(s, c));
            if (was_full && popping) chk("R10", "accepted while full", int'(ovf_err), int'(m_ovf));
         end else m_ovf = 1'b1;
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      #12;
      // R1: reset state, first cycle presents zero
      chk("R1", "out_valid", int'(out_valid), 0);
      chk("R1", "out_sum", int'(out_sum), 0);
      chk("R1", "out_carry", int'(out_carry), 0);
      chk("R1", "out_bin", int'(out_bin), 0);
      chk("R1", "fifo_empty", int'(fifo_empty), 1);
      chk("R1", "fifo_full", int'(fifo_full), 0);
      chk("R1", "ovf_err", int'(ovf_err), 0);
      @(negedge clk); rst_n = 1'b1;
      step(1'b0, '0, '0, 1'b0);                   // R7 idle zero
      // R2 bypass, including the 3:2 example pair 0b1011 / 0b0101
      step(1'b1, 8'h0B, 8'h05, 1'b0);
      step(1'b1, 8'hFF, 8'hFF, 1'b0);
      // R4 fill while busy, R8 full
      step(1'b1, 8'h10, 8'h01, 1'b1);
      step(1'b1, 8'h80, 8'h40, 1'b1);
      step(1'b1, 8'hF0, 8'h0A, 1'b1);
      // R9 overflow while full and busy, then sticky
      step(1'b1, 8'h33, 8'h33, 1'b1);
      step(1'b0, '0, '0, 1'b1);
      // R10 push and pop together while full; R6 new input queued behind
      step(1'b1, 8'h01, 8'h02, 1'b0);
      step(1'b1, 8'h05, 8'h00, 1'b0);
      // R5 drain
      for (int i = 0; i < 4; i++) step(1'b0, '0, '0, 1'b0);
      // clear overflow by reset
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      m_ovf = 1'b0; q.delete();
      for (int i = 0; i < 2000; i++)
         step(($urandom % 4) != 0, W'($urandom), W'($urandom), ($urandom % 5) < 2);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule